// File: doc/BRIEF.md
# Character Display Nibble-Bus Power-Up Sequencer

This block brings a character display module up from power-on to a usable state over a four-bit data path. After reset it waits for the supply to settle. It then sends three "attention" codes, each as a single upper-nibble write, followed by one single-nibble code that switches the display to four-bit operation. Four commands follow, each sent as a high nibble and then a low nibble: function set, display off, display on and entry mode.

The sequencer does not drive the display pins itself. It hands each nibble to a downstream transfer engine using a one-cycle request, and it issues a request only in a cycle where the engine reports idle. Display options come from five static configuration inputs: font height, cursor, blink, cursor direction and display shift. Every wait is a fixed minimum time, converted to clock cycles from the `CLK_HZ` parameter and rounded up. The busy flag is never read. When the final wait has elapsed, `ready` rises and stays high until the next reset.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rstN` is low, `wrReq` and `ready` are 0. After reset release, no request is issued until ceil(15 ms × CLK_HZ) idle cycles have elapsed. With CLK_HZ = 1,234,567 and a permanently idle engine, the first request falls in cycle 18519, counting the first cycle after release as cycle 0.
- R2: The first three writes carry nibble 4'b0011. They are followed by waits of 4.1 ms, 100 µs and 4.1 ms, in that order.
- R3: The fourth write carries nibble 4'b0010 and is followed by a 40 µs wait.
- R4: Function set is sent as nibble 4'b0010 and then {1, fontTall, 0, 0}. `wrNybble[3]` is the most significant data line.
- R5: Display off is sent as 4'b0000 then 4'b1000. Display on is sent as 4'b0000 then {1, 1, cursorOn, cursorBlink}.
- R6: Entry mode is the last command, sent as 4'b0000 then {0, 1, moveRight, shiftDisplay}.
- R7: The second nibble of a command is issued in the first cycle the engine is idle again after the first nibble, with no added wait. Each complete command is followed by a 40 µs wait.
- R8: Every wait of length t lasts ceil(t × CLK_HZ) cycles. Only cycles in which `engIdle` is high are counted. With CLK_HZ = 1,234,567 the four lengths are 18519, 5062, 124 and 50 cycles.
- R9: `wrReq` is high only in cycles where `engIdle` is high, for exactly one cycle per nibble, and for 12 nibbles in total.
- R10: `ready` rises one cycle after the final 40 µs wait reaches zero. It then stays high, with no further requests, until reset.
- R11: The configuration inputs are read in the cycle the nibble that carries them is issued, so a change made earlier in the sequence takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| engIdle | input | 1 | Transfer engine can accept a nibble |
| fontTall | input | 1 | 1 selects the 5x11 font, 0 selects 5x8 |
| cursorOn | input | 1 | Show the cursor |
| cursorBlink | input | 1 | Blink the cursor |
| moveRight | input | 1 | Cursor advances rightward |
| shiftDisplay | input | 1 | Display shifts on each write |
| wrReq | output | 1 | One-cycle nibble write request |
| wrNybble | output | 4 | Nibble to transfer, valid with wrReq |
| ready | output | 1 | Power-up sequence complete |

## Verification
The interesting coincidence is a wait reaching zero in the same cycle the transfer engine is still busy, or drops busy again. The request must slip to the first idle cycle, and the idle-gated countdown must not lose or gain a cycle. The bench provokes this with a periodic stall pattern on `engIdle` layered over a multi-cycle engine busy time. It also changes the configuration part-way through the sequence. A behavioural reference model, built from integer counters and the requirement values, predicts `wrReq`, `wrNybble` and `ready` in every cycle, and the bench compares the design against it.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int NUM_STEPS = 12;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);

  typedef enum logic [2:0] {
    DLY_NONE,
    DLY_LONG,
    DLY_SHORT,
    DLY_CMD
  } dly_e;

  typedef struct packed {
    logic              issue;
    dly_e              dly;
    logic [STEP_W-1:0] step;
  } seq_strobe_t;

  // time given in tenths of a microsecond, result rounded up
  function automatic longint unsigned ceilCycles(longint unsigned tenthsUs,
                                                 longint unsigned hz);
    return (tenthsUs * hz + 64'd9_999_999) / 64'd10_000_000;
  endfunction

endpackage

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        engIdle,
  input  logic        timerZero,
  output seq_strobe_t strb,
  output logic        ready
);

  typedef enum logic [1:0] {ST_RUN, ST_TAIL, ST_DONE} state_e;

  state_e            state;
  logic [STEP_W-1:0] stepCnt;
  logic              issueNow;
  dly_e              dlyAfter;

  assign issueNow = (state == ST_RUN) && timerZero && engIdle;

  always_comb begin
    unique case (int'(stepCnt))
      0, 2:              dlyAfter = DLY_LONG;
      1:                 dlyAfter = DLY_SHORT;
      3, 5, 7, 9, 11:    dlyAfter = DLY_CMD;
      default:           dlyAfter = DLY_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_RUN: if (issueNow) begin
          stepCnt <= stepCnt + 1'b1;
          if (int'(stepCnt) == NUM_STEPS - 1) state <= ST_TAIL;
        end
        ST_TAIL: if (timerZero) state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign strb.issue = issueNow;
  assign strb.dly   = dlyAfter;
  assign strb.step  = stepCnt;
  assign ready      = (state == ST_DONE);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R10
  ready_all_sent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (int'(stepCnt) == NUM_STEPS));

endmodule

// File: rtl/lcd_init_dpath.sv
module lcd_init_dpath
  import lcd_init_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 250_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        engIdle,
  input  seq_strobe_t strb,
  input  logic        fontTall,
  input  logic        cursorOn,
  input  logic        cursorBlink,
  input  logic        moveRight,
  input  logic        shiftDisplay,
  output logic        timerZero,
  output logic        wrReq,
  output logic [3:0]  wrNybble
);

  localparam longint unsigned T_POWER = ceilCycles(64'd150_000, CLK_HZ);
  localparam longint unsigned T_LONG  = ceilCycles(64'd41_000,  CLK_HZ);
  localparam longint unsigned T_SHORT = ceilCycles(64'd1_000,   CLK_HZ);
  localparam longint unsigned T_CMD   = ceilCycles(64'd400,     CLK_HZ);
  localparam int TW = $clog2(T_POWER + 1);

  localparam logic [TW-1:0] L_POWER = TW'(T_POWER);
  localparam logic [TW-1:0] L_LONG  = TW'(T_LONG);
  localparam logic [TW-1:0] L_SHORT = TW'(T_SHORT);
  localparam logic [TW-1:0] L_CMD   = TW'(T_CMD);

  logic [TW-1:0] timer;
  logic [TW-1:0] loadVal;
  logic [3:0]    nyb;

  always_comb begin
    unique case (strb.dly)
      DLY_LONG:  loadVal = L_LONG;
      DLY_SHORT: loadVal = L_SHORT;
      DLY_CMD:   loadVal = L_CMD;
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          timer <= L_POWER;
    else if (strb.issue)                timer <= loadVal;
    else if (engIdle && timer != '0)    timer <= timer - 1'b1;
  end

  assign timerZero = (timer == '0);

  always_comb begin
    unique case (int'(strb.step))
      0, 1, 2:   nyb = 4'b0011;
      3, 4:      nyb = 4'b0010;
      5:         nyb = {1'b1, fontTall, 2'b00};
      7:         nyb = 4'b1000;
      9:         nyb = {2'b11, cursorOn, cursorBlink};
      11:        nyb = {2'b01, moveRight, shiftDisplay};
      default:   nyb = 4'b0000;
    endcase
  end

  assign wrReq    = strb.issue;
  assign wrNybble = nyb;

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!engIdle && !strb.issue) |=> $stable(timer));

  // R8
  issue_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (timer == '0));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 250_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       engIdle,
  input  logic       fontTall,
  input  logic       cursorOn,
  input  logic       cursorBlink,
  input  logic       moveRight,
  input  logic       shiftDisplay,
  output logic       wrReq,
  output logic [3:0] wrNybble,
  output logic       ready
);

  seq_strobe_t strb;
  logic        timerZero;

  lcd_init_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .engIdle   (engIdle),
    .timerZero (timerZero),
    .strb      (strb),
    .ready     (ready)
  );

  lcd_init_dpath #(.CLK_HZ(CLK_HZ)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .engIdle      (engIdle),
    .strb         (strb),
    .fontTall     (fontTall),
    .cursorOn     (cursorOn),
    .cursorBlink  (cursorBlink),
    .moveRight    (moveRight),
    .shiftDisplay (shiftDisplay),
    .timerZero    (timerZero),
    .wrReq        (wrReq),
    .wrNybble     (wrNybble)
  );

  // R9
  req_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> engIdle);

  // R10
  quiet_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !wrReq);

endmodule

// File: tb/lcd_init_seq_tb.sv
`timescale 1ns/1ps
module lcd_init_seq_tb;

  localparam longint unsigned HZ = 1_234_567;
  // independently worked values for HZ
  localparam int E_POWER = 18519;
  localparam int E_LONG  = 5062;
  localparam int E_SHORT = 124;
  localparam int E_CMD   = 50;
  localparam int WD_LIMIT = 190_000;

  logic clk = 0;
  logic rstN = 0;
  logic engIdle = 1;
  logic fontTall = 0, cursorOn = 0, cursorBlink = 0, moveRight = 0, shiftDisplay = 0;
  logic wrReq;
  logic [3:0] wrNybble;
  logic ready;

  int checks = 0;
  int errors = 0;
  int totalCyc = 0;

  always #2 clk = ~clk;

  lcd_init_seq #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rstN(rstN), .engIdle(engIdle),
    .fontTall(fontTall), .cursorOn(cursorOn), .cursorBlink(cursorBlink),
    .moveRight(moveRight), .shiftDisplay(shiftDisplay),
    .wrReq(wrReq), .wrNybble(wrNybble), .ready(ready)
  );

  always @(posedge clk) begin
    totalCyc++;
    if (totalCyc >= WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: run hung, cycles=%0d expected<%0d", totalCyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input int idx);
    if (idx < 3) return "R2";
    if (idx == 3) return "R3";
    if (idx < 6) return "R4";
    if (idx < 10) return "R5";
    return "R6";
  endfunction

  function automatic int waitAfter(input int idx);
    case (idx)
      0, 2: return E_LONG;
      1: return E_SHORT;
      3, 5, 7, 9, 11: return E_CMD;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] expNyb(input int idx);
    case (idx)
      0, 1, 2: return 4'b0011;
      3, 4: return 4'b0010;
      5: return {1'b1, fontTall, 2'b00};
      7: return 4'b1000;
      9: return {2'b11, cursorOn, cursorBlink};
      11: return {2'b01, moveRight, shiftDisplay};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    engIdle = 1;
    repeat (3) @(negedge clk);
    #0.5;
    // R1 reset state
    check(wrReq == 0, "R1", wrReq, 0);
    check(ready == 0, "R1", ready, 0);
    rstN = 1;
  endtask

  task automatic runSeq(input int busyLen, input bit stall, input bit switchCfg);
    int idx = 0, rem = E_POWER, busy = 0, cyc = 0, reqs = 0, firstReq = -1, post = 0;
    bit expReady = 0, nextReady, idle, expReq;
    doReset();
    while (!(expReady && post >= 40)) begin
      if (cyc > 0) @(negedge clk);
      idle = (busy == 0) && !(stall && (cyc % 7) < 3);
      engIdle = idle;
      #0.5;
      expReq = (idx < 12) && (rem == 0) && idle;
      if (wrReq && !idle) check(0, "R9", wrReq, 0);
      check(wrReq == expReq, expReq ? tagOf(idx) : ((idx < 12) ? "R8" : "R10"), wrReq, expReq);
      if (expReq && wrReq) begin
        if (switchCfg && idx >= 5)
          check(wrNybble == expNyb(idx), "R11", wrNybble, expNyb(idx));
        else if (idx == 4 || idx == 6 || idx == 8 || idx == 10)
          check(wrNybble == expNyb(idx), "R7", wrNybble, expNyb(idx));
        else
          check(wrNybble == expNyb(idx), tagOf(idx), wrNybble, expNyb(idx));
      end
      check(ready == expReady, "R10", ready, expReady);
      if (wrReq) reqs++;
      nextReady = expReady || (idx == 12 && rem == 0);
      if (expReq) begin
        if (idx == 0) firstReq = cyc;
        rem = waitAfter(idx);
        idx++;
        busy = busyLen;
      end else begin
        if (idle && rem > 0) rem--;
        if (busy > 0) busy--;
      end
      if (expReady) post++;
      expReady = nextReady;
      if (switchCfg && idx == 4) begin
        fontTall = 1; cursorOn = 1; cursorBlink = 1; moveRight = 1; shiftDisplay = 1;
      end
      cyc++;
    end
    // R9 total count
    check(reqs == 12, "R9", reqs, 12);
    if (!stall) check(firstReq == E_POWER, "R1", firstReq, E_POWER);
    // R10 ready held, no more requests
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      engIdle = (k % 2 == 0);
      #0.5;
      check(ready == 1 && wrReq == 0, "R10", {ready, wrReq}, 2);
    end
  endtask

  initial begin
    fontTall = 0; cursorOn = 1; cursorBlink = 0; moveRight = 1; shiftDisplay = 0;
    runSeq(2, 0, 0);
    fontTall = 0; cursorOn = 0; cursorBlink = 0; moveRight = 0; shiftDisplay = 0;
    runSeq(5, 1, 1);
    doReset();
    @(negedge clk);
    #0.5;
    // R1 ready cleared by a fresh reset
    check(ready == 0, "R1", ready, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule